// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block produces the serial clock of an I2C master. A prescaler divides the system clock into a clock-enable tick. Three programmable tick counts then shape each SCL period: a low time, a high time and a minimum full-cycle time. The block drives SCL low for the low time and then releases the line. It starts the high time only after it has seen the line actually go high, so a target that holds SCL low (clock stretching) lengthens the period.

A sequencer that runs START, STOP and data bits uses two strobes. One strobe falls in the middle of every low phase, where SDA may change. The other falls in the middle of every high phase, where SDA is sampled. Configuration arrives through a small write port with two words. One word holds the serial-clock enable and the divider. The other holds the three packed counts. A run input starts and stops the clock.

Top module: `scl_timegen`

## Requirements
- R1: A write with `cfg_addr`=0 loads the enable from bit 0 and the divider from bits 15:4. A write with `cfg_addr`=1 loads the high count from bits 29:20, the low count from bits 19:10 and the cycle count from bits 9:0.
- R2: While `run` and the enable are both set, `tick` pulses for one cycle every D system cycles, with D the divider. Each low phase holds exactly L ticks, with L the low count.
- R3: `scl_oe` stays asserted (SCL driven low) for exactly L×D cycles in each low phase, including the first low phase after enabling.
- R4: After a release, the high phase starts only once the synchronised line reads high and at least SYNC_STAGES cycles have passed since the release. With no stretching, the released time is SYNC_STAGES+1+N×D cycles, where N = max(H, C−L), H is the high count and C is the cycle count.
- R5: Each extra cycle in which the line is held low after release lengthens the released time by exactly one cycle.
- R6: A cycle count larger than L+H extends the high phase, so that the total tick count over low and high is C.
- R7: `drive_stb` pulses exactly once per low phase, and never while SCL is released. The pulse comes ((L>>1)+1)×D−1 cycles after the first low cycle.
- R8: `sample_stb` pulses exactly once per high phase, and never while SCL is driven low. The pulse comes ((H>>1)+1)×D−1 cycles after the high phase starts, counted from the tick-free start of that phase.
- R9: When `run` is low or the enable is clear, `scl_oe` is released at the next edge and `tick` and both strobes stay low. Re-enabling starts a full low phase at the next edge.
- R10: A divider, low count or high count of zero acts as one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | 0: enable/divider word, 1: packed count word |
| cfg_wdata | input | 32 | Configuration write data |
| run | input | 1 | Sequencer request to generate the clock |
| scl_in | input | 1 | Sampled level of the SCL line |
| scl_oe | output | 1 | 1 drives SCL low, 0 releases it |
| tick | output | 1 | Divided clock-enable pulse |
| drive_stb | output | 1 | Mid-low strobe for changing SDA |
| sample_stb | output | 1 | Mid-high strobe for sampling SDA |

## Verification
The bench builds the block with its default parameters: a 12-bit divider, 10-bit counts and a two-stage line synchroniser. These values reach the three standard-rate settings, zero counts and a cycle count that stretches the high phase well past its nominal length. SCL is looped back through a wired-AND model, so the bench can hold the line low for a chosen number of cycles and observe the extra released time. Random dividers from 0 to 4 and counts up to 12 keep every period short, so many configurations fit in one run. Very large counts near the 10-bit limit are reached only by the reasoning behind the counter widths.

// File: rtl/scl_timegen_pkg.sv
package scl_timegen_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_WAIT = 2'd2,
        PH_HIGH = 2'd3
    } scl_phase_e;

    localparam int CFG_WORD_W  = 32;
    localparam int CFG_DIV_LSB = 4;
endpackage

// File: rtl/scl_cfg_regs.sv
module scl_cfg_regs
    import scl_timegen_pkg::*;
#(
    parameter int DIV_W = 12,
    parameter int CNT_W = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic                  addr,
    input  logic [CFG_WORD_W-1:0] wdata,
    output logic                  clk_en,
    output logic [DIV_W-1:0]      div,
    output logic [CNT_W-1:0]      hi_cnt,
    output logic [CNT_W-1:0]      lo_cnt,
    output logic [CNT_W-1:0]      cyc_cnt
);
    localparam int PACK_W = 3 * CNT_W;

    typedef struct packed {
        logic             en;
        logic [DIV_W-1:0] div;
        logic [CNT_W-1:0] hi;
        logic [CNT_W-1:0] lo;
        logic [CNT_W-1:0] cyc;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            if (!addr) begin
                cfg_d.en  = wdata[0];
                cfg_d.div = wdata[CFG_DIV_LSB +: DIV_W];
            end else begin
                cfg_d.hi  = wdata[2*CNT_W +: CNT_W];
                cfg_d.lo  = wdata[CNT_W +: CNT_W];
                cfg_d.cyc = wdata[0 +: CNT_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    generate
        if (PACK_W < CFG_WORD_W) begin : g_spare
            logic unused_spare;
            assign unused_spare = ^wdata[CFG_WORD_W-1:PACK_W];
        end
    endgenerate

    assign clk_en  = cfg_q.en;
    assign div     = cfg_q.div;
    assign hi_cnt  = cfg_q.hi;
    assign lo_cnt  = cfg_q.lo;
    assign cyc_cnt = cfg_q.cyc;
endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             hold,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] div_eff;
    logic [DIV_W-1:0] pre_d, pre_q;

    always_comb begin
        div_eff = (div == '0) ? DIV_W'(1) : div;
        tick    = active && !hold && (pre_q >= div_eff - 1'b1);
        if (!active || hold || tick) pre_d = '0;
        else                         pre_d = pre_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // Two ticks never sit back to back unless the divide ratio is one.
    assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_eff > DIV_W'(1) && $stable(div)) |=> !tick);

    // No tick while the clock is stopped.
    assert_tick_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !tick);
endmodule

// File: rtl/scl_line_sync.sv
module scl_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_sync
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        sh_d[0] = line_in;
        for (int i = 1; i < STAGES; i++) sh_d[i] = sh_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign line_sync = sh_q[STAGES-1];
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_timegen_pkg::*;
#(
    parameter int CNT_W  = 10,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             tick,
    input  logic             scl_sync,
    input  logic [CNT_W-1:0] hi_cnt,
    input  logic [CNT_W-1:0] lo_cnt,
    input  logic [CNT_W-1:0] cyc_cnt,
    output logic             scl_oe,
    output logic             hold_pre,
    output logic             drive_stb,
    output logic             sample_stb
);
    localparam int WAIT_W = $clog2(STAGES + 1);

    typedef struct packed {
        scl_phase_e        phase;
        logic [CNT_W-1:0]  lcnt;
        logic [CNT_W-1:0]  hcnt;
        logic [CNT_W:0]    ccnt;
        logic [WAIT_W-1:0] wcnt;
    } fsm_t;

    fsm_t             s_d, s_q;
    logic [CNT_W-1:0] lo_eff, hi_eff;
    logic [CNT_W:0]   l_nx, h_nx, c_nx;

    always_comb begin
        s_d        = s_q;
        drive_stb  = 1'b0;
        sample_stb = 1'b0;
        lo_eff     = (lo_cnt == '0) ? CNT_W'(1) : lo_cnt;
        hi_eff     = (hi_cnt == '0) ? CNT_W'(1) : hi_cnt;
        l_nx       = {1'b0, s_q.lcnt} + 1'b1;
        h_nx       = {1'b0, s_q.hcnt} + 1'b1;
        c_nx       = s_q.ccnt + 1'b1;
        if (!active) begin
            s_d = '0;
        end else begin
            case (s_q.phase)
                PH_IDLE: begin
                    s_d       = '0;
                    s_d.phase = PH_LOW;
                end
                PH_LOW: begin
                    if (tick) begin
                        drive_stb = (s_q.lcnt == (lo_eff >> 1));
                        s_d.lcnt  = l_nx[CNT_W-1:0];
                        s_d.ccnt  = c_nx;
                        if (l_nx >= {1'b0, lo_eff}) begin
                            s_d.phase = PH_WAIT;
                            s_d.wcnt  = '0;
                        end
                    end
                end
                PH_WAIT: begin
                    if (s_q.wcnt < WAIT_W'(STAGES)) s_d.wcnt = s_q.wcnt + 1'b1;
                    if (s_q.wcnt >= WAIT_W'(STAGES) && scl_sync) begin
                        s_d.phase = PH_HIGH;
                        s_d.hcnt  = '0;
                    end
                end
                PH_HIGH: begin
                    if (tick) begin
                        sample_stb = (s_q.hcnt == (hi_eff >> 1));
                        s_d.hcnt   = h_nx[CNT_W-1:0];
                        s_d.ccnt   = c_nx;
                        if (h_nx >= {1'b0, hi_eff} && c_nx >= {1'b0, cyc_cnt}) begin
                            s_d.phase = PH_LOW;
                            s_d.lcnt  = '0;
                            s_d.hcnt  = '0;
                            s_d.ccnt  = '0;
                        end
                    end
                end
                default: s_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign scl_oe   = (s_q.phase == PH_LOW);
    assign hold_pre = (s_q.phase == PH_IDLE) || (s_q.phase == PH_WAIT);

    // Low counter stays inside the programmed low time.
    assert_low_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_LOW && $stable(lo_cnt)) |-> (s_q.lcnt < lo_eff));

    // High phase is entered only on a line that reads high.
    assert_high_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_HIGH && $past(s_q.phase) == PH_WAIT) |-> $past(scl_sync));

    // A new low phase after high means the full-cycle count was reached.
    assert_cycle_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_LOW && $past(s_q.phase) == PH_HIGH)
        |-> ($past(s_q.ccnt) + 1'b1 >= {1'b0, $past(cyc_cnt)}));

    // SDA change strobe only while SCL is held low.
    assert_drive_in_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        drive_stb |-> scl_oe);

    // The two strobes never coincide, and sampling happens with SCL released.
    assert_sample_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> (!scl_oe && $onehot0({drive_stb, sample_stb})));

    // Stopping releases SCL on the next edge.
    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !scl_oe);
endmodule

// File: rtl/scl_timegen.sv
module scl_timegen
    import scl_timegen_pkg::*;
#(
    parameter int DIV_W       = 12,
    parameter int CNT_W       = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic        cfg_addr,
    input  logic [31:0] cfg_wdata,
    input  logic        run,
    input  logic        scl_in,
    output logic        scl_oe,
    output logic        tick,
    output logic        drive_stb,
    output logic        sample_stb
);
    logic             clk_en;
    logic [DIV_W-1:0] div;
    logic [CNT_W-1:0] hi_cnt, lo_cnt, cyc_cnt;
    logic             active;
    logic             hold_pre;
    logic             scl_sync;

    assign active = run && clk_en;

    scl_cfg_regs #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .clk_en  (clk_en),
        .div     (div),
        .hi_cnt  (hi_cnt),
        .lo_cnt  (lo_cnt),
        .cyc_cnt (cyc_cnt)
    );

    scl_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active),
        .hold   (hold_pre),
        .div    (div),
        .tick   (tick)
    );

    scl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (scl_in),
        .line_sync (scl_sync)
    );

    scl_phase_fsm #(.CNT_W(CNT_W), .STAGES(SYNC_STAGES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (active),
        .tick       (tick),
        .scl_sync   (scl_sync),
        .hi_cnt     (hi_cnt),
        .lo_cnt     (lo_cnt),
        .cyc_cnt    (cyc_cnt),
        .scl_oe     (scl_oe),
        .hold_pre   (hold_pre),
        .drive_stb  (drive_stb),
        .sample_stb (sample_stb)
    );
endmodule

// File: tb/scl_timegen_tb.sv
module scl_timegen_tb;
    localparam int SYNC = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_addr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        run = 1'b0;
    logic        hold_line = 1'b0;
    logic        scl_in;
    logic        scl_oe, tick, drive_stb, sample_stb;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    assign scl_in = !scl_oe && !hold_line;

    scl_timegen #(.DIV_W(12), .CNT_W(10), .SYNC_STAGES(SYNC)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .run(run), .scl_in(scl_in), .scl_oe(scl_oe),
        .tick(tick), .drive_stb(drive_stb), .sample_stb(sample_stb)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int high_ticks(input int h, input int l, input int c);
        int n;
        n = eff(h);
        if (c - eff(l) > n) n = c - eff(l);
        return n;
    endfunction

    task automatic write_cfg(input logic a, input logic [31:0] v);
        cfg_addr  = a;
        cfg_wdata = v;
        cfg_we    = 1'b1;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic measure(input int hold,
                           output int llen, output int lpos, output int lnum,
                           output int ltk, output int lbad,
                           output int hlen, output int hpos, output int hnum,
                           output int hbad);
        llen = 0; lpos = -1; lnum = 0; ltk = 0; lbad = 0;
        hlen = 0; hpos = -1; hnum = 0; hbad = 0;
        while (scl_oe) begin
            if (drive_stb) begin lpos = llen; lnum++; end
            if (sample_stb) lbad++;
            if (tick) ltk++;
            llen++;
            @(negedge clk);
        end
        hold_line = (hold > 0);
        while (!scl_oe) begin
            if (hlen == hold) hold_line = 1'b0;
            if (sample_stb) begin hpos = hlen; hnum++; end
            if (drive_stb) hbad++;
            hlen++;
            @(negedge clk);
        end
    endtask

    task automatic run_case(input int d, input int h, input int l, input int c, input int hold2);
        int llen, lpos, lnum, ltk, lbad, hlen, hpos, hnum, hbad;
        int de, n, hold;
        run = 1'b0;
        @(negedge clk);
        write_cfg(1'b0, (32'(d) << 4) | 32'd1);
        write_cfg(1'b1, (32'(h) << 20) | (32'(l) << 10) | 32'(c));
        run = 1'b1;
        @(negedge clk);
        chk("R9 low phase begins right after enable", int'(scl_oe), 1);
        de = eff(d);
        n  = high_ticks(h, l, c);
        for (int p = 0; p < 2; p++) begin
            hold = (p == 0) ? 0 : hold2;
            measure(hold, llen, lpos, lnum, ltk, lbad, hlen, hpos, hnum, hbad);
            chk("R3 low length", llen, eff(l) * de);
            chk("R2 ticks per low phase", ltk, eff(l));
            chk("R7 drive strobe count", lnum, 1);
            chk("R7 drive strobe position", lpos, ((eff(l) >> 1) + 1) * de - 1);
            chk("R8 no sample strobe in low", lbad, 0);
            if (hold == 0) chk("R4 R6 released length", hlen, SYNC + 1 + n * de);
            else           chk("R5 stretched length", hlen, SYNC + 1 + hold + n * de);
            chk("R8 sample strobe count", hnum, 1);
            chk("R8 sample strobe position", hpos, SYNC + hold + ((eff(h) >> 1) + 1) * de);
            chk("R7 no drive strobe in high", hbad, 0);
        end
        run = 1'b0;
        @(negedge clk);
        chk("R9 released after stop", int'(scl_oe), 0);
    endtask

    task automatic quiet_window(input string req, input int cycles);
        int act;
        act = 0;
        for (int i = 0; i < cycles; i++) begin
            if (scl_oe || tick || drive_stb || sample_stb) act++;
            @(negedge clk);
        end
        chk(req, act, 0);
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 reset: scl released", int'(scl_oe), 0);
        chk("R9 reset: no tick", int'(tick), 0);
        quiet_window("R9 reset: quiet with run low", 8);

        // R1 field decode exercised through three standard-rate settings.
        run_case(7, 10, 11, 26, 0);
        run_case(2, 5, 12, 24, 4);
        run_case(1, 3, 9, 18, 9);
        // R10 zero divider and counts behave as one.
        run_case(0, 0, 0, 0, 1);
        // R6 cycle count smaller than low plus high has no effect.
        run_case(3, 8, 4, 5, 20);
        // R6 long cycle count stretches high.
        run_case(2, 2, 3, 40, 2);

        for (int k = 0; k < 14; k++) begin
            int d, h, l, c, hd;
            d  = int'($urandom % 5);
            h  = int'($urandom % 13);
            l  = int'($urandom % 13);
            c  = int'($urandom % 31);
            hd = int'($urandom % 7);
            run_case(d, h, l, c, hd);
        end

        // R9 enable bit clear keeps everything quiet even with run high.
        write_cfg(1'b0, (32'd2 << 4));
        run = 1'b1;
        @(negedge clk);
        quiet_window("R9 enable clear", 20);
        run = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule